// File: doc/BRIEF.md
# Serial EEPROM Write-Protect Switch Controller

This block sits behind the byte-level front end of a two-wire serial EEPROM slave. The front end hands it decoded bus events: a start strobe, a stop strobe and a strobe for every received byte together with that byte. The block recognises the protection commands, which all carry the slave-address preamble `0110` in bits [7:4] of the first byte after a start. It keeps two protection switches: a reversible one and a permanent one that, once set, can never be cleared. For every byte it decides whether the slave drives an acknowledge. It also runs the internal write cycle that commits a switch change after the stop.

The high-voltage condition on an address pin reaches the block as one digital qualifier, `hv_in`, sampled with the slave-address byte. Bit 0 of that byte, the read/write position, selects between the command variants. The write-protect pin `wp_in` is sampled with the third byte, which is the data byte. All inputs are plain, single-cycle control strobes with no back-pressure: a byte strobe is consumed in the cycle it is seen, and it is never held off.

Top module: `wp_switch_ctrl`

## Requirements
- R1: Power-on reset (`por_n` low) clears both switches. The functional reset (`rst_n` low) clears the reversible switch, `ack_en` and `busy`, but leaves `perm_prot` unchanged.
- R2: The command is decoded from the first byte after a start, and only when bits [7:4] equal 4'b0110. `hv_in`=0 with bit0=0 means permanent-set. `hv_in`=1 with bit0=0 means reversible-set. `hv_in`=1 with bit0=1 means reversible-clear. Any other first byte (other preamble, or `hv_in`=0 with bit0=1) is never acknowledged and changes nothing.
- R3: Each byte strobe updates `ack_en` at the next clock edge, and `ack_en` then holds until the next byte, start or stop. An accepted command acknowledges its command byte, its address byte and its data byte.
- R4: While `perm_prot` is 1, no byte is ever acknowledged.
- R5: A command that would leave its switch unchanged (reversible-set while `rev_prot`=1, reversible-clear while `rev_prot`=0) is not acknowledged at its command byte, at any `wp_in` level. Its later bytes are not acknowledged either.
- R6: When an accepted command meets `wp_in`=1 at its data byte, the command and address bytes are acknowledged, the data byte is not, and no switch changes.
- R7: A change is committed only by a stop that directly follows exactly three bytes with an acknowledged data byte. A fourth or later byte is not acknowledged and cancels the commit. A stop after fewer bytes changes nothing and starts no write cycle.
- R8: A commit raises `busy` at the clock edge that samples the stop. `busy` stays high for WCYCLE cycles. The switch takes its new value at the same edge where `busy` falls, and not before.
- R9: While `busy` is high, byte strobes are ignored and not acknowledged.
- R10: Once set, `perm_prot` stays 1 through any traffic and through functional reset. Only power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, async; clears everything |
| rst_n | input | 1 | Functional reset, active low, async; spares `perm_prot` |
| bus_start | input | 1 | Start or repeated start seen (one-cycle strobe) |
| bus_stop | input | 1 | Stop seen (one-cycle strobe) |
| byte_valid | input | 1 | A byte has been received (one-cycle strobe) |
| byte_data | input | 8 | Received byte, valid with `byte_valid` |
| hv_in | input | 1 | High-voltage qualifier, sampled with the slave-address byte |
| wp_in | input | 1 | Write-protect pin level, sampled with the data byte |
| ack_en | output | 1 | Drive acknowledge for the most recent byte |
| busy | output | 1 | Internal write cycle in progress |
| perm_prot | output | 1 | Permanent protection switch |
| rev_prot | output | 1 | Reversible protection switch |

## Verification
Directed transactions walk the reversible switch through set, reaffirm, clear and reaffirm. Each is sent with `wp_in` low and high, which separates a refused flip (data byte not acknowledged) from a refused reaffirm (command byte not acknowledged). Frames of two and four bytes, foreign preambles and the unused `hv_in`=0 read variant show that only an exact, acknowledged three-byte frame commits. A byte poked during the write cycle, with the switch sampled one cycle before and at the end of `busy`, pins down the commit timing. Randomly generated frames then mix preamble, qualifier, direction bit, length and `wp_in`, first with the permanent switch clear and then with it set. These frames are followed by functional and power-on resets that tell the two reset domains apart.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PERM = 2'd1,
    OP_RSET = 2'd2,
    OP_RCLR = 2'd3
  } wp_op_e;

  localparam logic [3:0] PROT_PREAMBLE = 4'b0110;
endpackage

// File: rtl/wps_decode.sv
module wps_decode
  import wps_pkg::*;
(
  input  logic [7:0] first_byte,
  input  logic       hv_q,
  input  logic       perm_now,
  input  logic       rev_now,
  output wp_op_e     op,
  output logic       accept
);
  logic unused_dev_bits;
  assign unused_dev_bits = ^first_byte[3:1];

  always_comb begin
    op = OP_NONE;
    if (first_byte[7:4] == PROT_PREAMBLE) begin
      unique case ({hv_q, first_byte[0]})
        2'b00:   op = OP_PERM;
        2'b10:   op = OP_RSET;
        2'b11:   op = OP_RCLR;
        default: op = OP_NONE;
      endcase
    end
  end

  always_comb begin
    accept = 1'b0;
    if (!perm_now) begin
      unique case (op)
        OP_PERM: accept = 1'b1;
        OP_RSET: accept = !rev_now;
        OP_RCLR: accept = rev_now;
        default: accept = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wps_seq.sv
module wps_seq
  import wps_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bus_start,
  input  logic   bus_stop,
  input  logic   byte_valid,
  input  logic   wp_in,
  input  logic   busy,
  input  logic   rev_now,
  input  wp_op_e dec_op,
  input  logic   dec_accept,
  output logic   ack_en,
  output logic   commit_req,
  output wp_op_e commit_op
);
  logic [1:0] idx;
  logic       acc_q;
  logic       data_ok;
  wp_op_e     op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= 2'd0;
      acc_q   <= 1'b0;
      data_ok <= 1'b0;
      ack_en  <= 1'b0;
      op_q    <= OP_NONE;
    end else if (bus_start) begin
      idx     <= 2'd0;
      acc_q   <= 1'b0;
      data_ok <= 1'b0;
      ack_en  <= 1'b0;
      op_q    <= OP_NONE;
    end else if (bus_stop) begin
      idx     <= 2'd0;
      acc_q   <= 1'b0;
      data_ok <= 1'b0;
      ack_en  <= 1'b0;
    end else if (byte_valid) begin
      if (busy) begin
        idx     <= 2'd3;
        acc_q   <= 1'b0;
        data_ok <= 1'b0;
        ack_en  <= 1'b0;
      end else begin
        unique case (idx)
          2'd0: begin
            acc_q  <= dec_accept;
            op_q   <= dec_op;
            ack_en <= dec_accept;
            idx    <= 2'd1;
          end
          2'd1: begin
            ack_en <= acc_q;
            idx    <= 2'd2;
          end
          2'd2: begin
            data_ok <= acc_q && !wp_in;
            ack_en  <= acc_q && !wp_in;
            idx     <= 2'd3;
          end
          default: begin
            data_ok <= 1'b0;
            ack_en  <= 1'b0;
          end
        endcase
      end
    end
  end

  assign commit_req = bus_stop && !bus_start && !busy && (idx == 2'd3) && data_ok;
  assign commit_op  = op_q;

  // R6
  wp_data_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !bus_start && !bus_stop && !busy && idx == 2'd2 && wp_in) |=> !ack_en);

  // R5
  reaffirm_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !bus_start && !bus_stop && !busy && idx == 2'd0 &&
     ((dec_op == OP_RSET && rev_now) || (dec_op == OP_RCLR && !rev_now))) |=> !ack_en);

  // R7
  extra_byte_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !bus_start && !bus_stop && idx == 2'd3) |=> (!ack_en && !data_ok));
endmodule

// File: rtl/wps_timer.sv
module wps_timer
  import wps_pkg::*;
#(
  parameter int WCYCLE = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   commit_req,
  input  wp_op_e commit_op,
  output logic   busy,
  output logic   done,
  output wp_op_e done_op
);
  localparam int CNT_W = (WCYCLE > 2) ? $clog2(WCYCLE) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      done_op <= OP_NONE;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (commit_req) begin
      busy    <= 1'b1;
      cnt     <= CNT_W'(WCYCLE - 1);
      done_op <= commit_op;
    end
  end

  assign done = busy && (cnt == '0);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);

  // R8
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == CNT_W'(WCYCLE - 1)));
endmodule

// File: rtl/wps_switches.sv
module wps_switches
  import wps_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   rst_n,
  input  logic   done,
  input  wp_op_e done_op,
  output logic   perm_prot,
  output logic   rev_prot
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         perm_prot <= 1'b0;
    else if (done && done_op == OP_PERM) perm_prot <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rev_prot <= 1'b0;
    else if (done) begin
      if (done_op == OP_RSET)      rev_prot <= 1'b1;
      else if (done_op == OP_RCLR) rev_prot <= 1'b0;
    end
  end

  // R10
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    perm_prot |=> perm_prot);

  // R8
  rev_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rev_prot));
endmodule

// File: rtl/wp_switch_ctrl.sv
module wp_switch_ctrl
  import wps_pkg::*;
#(
  parameter int WCYCLE = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       hv_in,
  input  logic       wp_in,
  output logic       ack_en,
  output logic       busy,
  output logic       perm_prot,
  output logic       rev_prot
);
  logic   fn_rst_n;
  wp_op_e dec_op;
  logic   dec_accept;
  logic   commit_req;
  wp_op_e commit_op;
  logic   done;
  wp_op_e done_op;

  assign fn_rst_n = rst_n & por_n;

  wps_decode u_decode (
    .first_byte (byte_data),
    .hv_q       (hv_in),
    .perm_now   (perm_prot),
    .rev_now    (rev_prot),
    .op         (dec_op),
    .accept     (dec_accept)
  );

  wps_seq u_seq (
    .clk        (clk),
    .rst_n      (fn_rst_n),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .byte_valid (byte_valid),
    .wp_in      (wp_in),
    .busy       (busy),
    .rev_now    (rev_prot),
    .dec_op     (dec_op),
    .dec_accept (dec_accept),
    .ack_en     (ack_en),
    .commit_req (commit_req),
    .commit_op  (commit_op)
  );

  wps_timer #(.WCYCLE(WCYCLE)) u_timer (
    .clk        (clk),
    .rst_n      (fn_rst_n),
    .commit_req (commit_req),
    .commit_op  (commit_op),
    .busy       (busy),
    .done       (done),
    .done_op    (done_op)
  );

  wps_switches u_sw (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (fn_rst_n),
    .done      (done),
    .done_op   (done_op),
    .perm_prot (perm_prot),
    .rev_prot  (rev_prot)
  );

  // R4
  perm_no_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
    perm_prot |-> !ack_en);

  // R9
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!fn_rst_n)
    busy |=> !ack_en);
endmodule

// File: tb/tb_wp_switch_ctrl.sv
module tb_wp_switch_ctrl;
  localparam int WCYCLE = 16;

  logic       clk = 1'b0;
  logic       por_n, rst_n, bus_start, bus_stop, byte_valid, hv_in, wp_in;
  logic [7:0] byte_data;
  logic       ack_en, busy, perm_prot, rev_prot;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  bit  m_perm = 1'b0;
  bit  m_rev  = 1'b0;

  always #10 clk = ~clk;

  wp_switch_ctrl #(.WCYCLE(WCYCLE)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_start(bus_start),
    .bus_stop(bus_stop), .byte_valid(byte_valid), .byte_data(byte_data),
    .hv_in(hv_in), .wp_in(wp_in), .ack_en(ack_en), .busy(busy),
    .perm_prot(perm_prot), .rev_prot(rev_prot)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 permanent-set, 2 reversible-set, 3 reversible-clear
  function automatic int exp_op(input logic [7:0] s, input bit hv);
    if (s[7:4] != 4'b0110) return 0;
    if (!hv) return s[0] ? 0 : 1;
    return s[0] ? 3 : 2;
  endfunction

  function automatic bit exp_accept(input int op, input bit perm, input bit rev);
    if (perm) return 1'b0;
    case (op)
      1: return 1'b1;
      2: return !rev;
      3: return rev;
      default: return 1'b0;
    endcase
  endfunction

  task automatic pulse_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit hv, input bit wp);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = d; hv_in = hv; wp_in = wp;
    @(negedge clk);
    byte_valid = 1'b0; hv_in = $urandom_range(0, 1); wp_in = $urandom_range(0, 1);
  endtask

  task automatic check_flags(input string req);
    chk({req, " perm_prot"}, 32'(perm_prot), 32'(m_perm));
    chk({req, " rev_prot"}, 32'(rev_prot), 32'(m_rev));
  endtask

  task automatic run_cmd(input logic [7:0] slave, input bit hv, input int nbytes,
                         input bit wp, input bit poke, input string req);
    int  op;
    bit  acc;
    bit  commit;
    op  = exp_op(slave, hv);
    acc = exp_accept(op, m_perm, m_rev);
    pulse_start();
    for (int i = 0; i < nbytes; i++) begin
      bit ea;
      if (i == 0) send_byte(slave, hv, $urandom_range(0, 1));
      else if (i == 2) send_byte(8'($urandom), $urandom_range(0, 1), wp);
      else send_byte(8'($urandom), $urandom_range(0, 1), $urandom_range(0, 1));
      ea = (i < 2) ? acc : (i == 2) ? (acc && !wp) : 1'b0;
      chk($sformatf("%s ack byte%0d", req, i), 32'(ack_en), 32'(ea));
    end
    commit = (nbytes == 3) && acc && !wp;
    pulse_stop();
    if (commit) begin
      for (int k = 0; k < WCYCLE - 1; k++) begin
        @(negedge clk);
        if (poke && k == 0) begin byte_valid = 1'b1; byte_data = 8'h60; hv_in = 1'b1; end
        if (poke && k == 1) begin
          byte_valid = 1'b0;
          chk("R9 no ack while busy", 32'(ack_en), 32'd0);
        end
      end
      chk("R8 busy held", 32'(busy), 32'd1);
      check_flags("R8 unchanged before end of cycle");
      @(negedge clk);
      chk("R8 busy dropped", 32'(busy), 32'd0);
      if (op == 1) m_perm = 1'b1;
      else if (op == 2) m_rev = 1'b1;
      else if (op == 3) m_rev = 1'b0;
      check_flags(req);
    end else begin
      chk("R7 no write cycle", 32'(busy), 32'd0);
      check_flags("R7 no change");
    end
  endtask

  task automatic do_reset(input bit por);
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    m_rev = 1'b0;
    if (por) m_perm = 1'b0;
    check_flags(por ? "R1 R10 power-on reset" : "R1 R10 functional reset");
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 ack after reset", 32'(ack_en), 32'd0);
  endtask

  task automatic random_cmds(input int n, input bit allow_perm);
    for (int j = 0; j < n; j++) begin
      logic [7:0] s;
      bit hv;
      int nb;
      s  = 8'($urandom);
      if ($urandom_range(0, 3) != 0) s[7:4] = 4'b0110;
      hv = $urandom_range(0, 1);
      if (!allow_perm && !hv && !s[0]) hv = 1'b1;
      nb = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 3;
      run_cmd(s, hv, nb, $urandom_range(0, 3) == 0, $urandom_range(0, 1), "R2 R3 random");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    por_n = 1'b0; rst_n = 1'b0;
    bus_start = 1'b0; bus_stop = 1'b0; byte_valid = 1'b0;
    byte_data = 8'h00; hv_in = 1'b0; wp_in = 1'b0;
    repeat (3) @(negedge clk);
    check_flags("R1 power-on state");
    chk("R1 ack at reset", 32'(ack_en), 32'd0);
    chk("R1 busy at reset", 32'(busy), 32'd0);
    por_n = 1'b1; rst_n = 1'b1;

    run_cmd(8'h60, 1'b1, 3, 1'b0, 1'b0, "R3 reversible set");
    run_cmd(8'h64, 1'b1, 3, 1'b1, 1'b0, "R5 reaffirm set wp high");
    run_cmd(8'h62, 1'b1, 3, 1'b0, 1'b0, "R5 reaffirm set wp low");
    run_cmd(8'h61, 1'b1, 3, 1'b1, 1'b0, "R6 clear refused by wp");
    run_cmd(8'h61, 1'b1, 2, 1'b0, 1'b0, "R7 early stop");
    run_cmd(8'h61, 1'b1, 4, 1'b0, 1'b0, "R7 extra byte");
    run_cmd(8'h6f, 1'b1, 3, 1'b0, 1'b1, "R9 R2 reversible clear");
    run_cmd(8'h61, 1'b1, 3, 1'b0, 1'b0, "R5 reaffirm clear");
    run_cmd(8'ha0, 1'b1, 3, 1'b0, 1'b0, "R2 foreign preamble");
    run_cmd(8'h61, 1'b0, 3, 1'b0, 1'b0, "R2 read variant");
    run_cmd(8'h60, 1'b1, 3, 1'b0, 1'b0, "R3 set again");
    do_reset(1'b0);

    random_cmds(120, 1'b0);

    run_cmd(8'h60, 1'b0, 3, 1'b1, 1'b0, "R6 permanent refused by wp");
    run_cmd(8'h6e, 1'b0, 3, 1'b0, 1'b1, "R8 permanent set");
    run_cmd(8'h60, 1'b0, 3, 1'b0, 1'b0, "R4 permanent reaffirm");
    run_cmd(8'h60, 1'b1, 3, 1'b0, 1'b0, "R4 set after permanent");
    random_cmds(30, 1'b1);
    do_reset(1'b0);
    run_cmd(8'h60, 1'b1, 3, 1'b0, 1'b0, "R4 R10 after functional reset");
    do_reset(1'b1);
    run_cmd(8'h60, 1'b1, 3, 1'b0, 1'b0, "R10 usable after power-on");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule